// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns start and stop commands into the four logic-level coil phase signals of a four-phase stepper motor. External high-current drivers then power the coils from these signals. It offers three drive formats. Each rotation direction has its own step pulse width and step count. Speed can ramp up on start and ramp down on stop, and a host stop can be made to act at once, cutting the ramp short.

A host programs a small register file, then pulses `start_req`. From that point the block walks a 3-bit position index one step per pulse width. Two latched sensor event inputs can stop the motor or reverse its direction. While the speed is ramping, such events wait and act only when the ramp has finished. Pulse widths are counted in ticks of a free-running prescaler that divides `clk` by `TICK_DIV`.

Top module: `step_phase_seq`

## Requirements
- R1: Register writes (`cfg_we`) select by `cfg_addr`. Address 0 is control: bits [1:0] format, [2] hold, [3] ramp-up enable, [4] ramp-down enable, [8:5] rate code, [9] hard-stop enable, [10] start direction (1 = counter-clockwise). Address 1 is the clockwise width, 2 the counter-clockwise width, 3 the clockwise count and 4 the counter-clockwise count. Reset clears all of them.
- R2: Coil pattern from index i. Format 0 (wave) drives bit i mod 4 alone. Format 1 (two-phase) drives bits i mod 4 and (i+1) mod 4. Format 2 (half-step) drives bit i/2 for even i, and bits i/2 and (i/2+1) mod 4 for odd i.
- R3: The first start after reset energises index 0 for clockwise, or the last index (3, or 7 in half-step) for counter-clockwise, on the edge that samples `start_req`. This reference position is not counted as a step.
- R4: Each step moves the index by +1 (clockwise) or −1 (counter-clockwise), wrapping at 4, or at 8 in half-step. With no ramp, steps are width×TICK_DIV cycles apart, using the width of the current direction. A width of 0 acts as 1.
- R5: A count of N gives exactly N steps. The run ends one width after the last step. A count of 0 rotates until stopped.
- R6: While idle after a run, the coils show the held position if hold is 1 and all zero if hold is 0.
- R7: With ramp-up enabled, the width starts at RAMP_MAX. At each step it shrinks by rate+1, but never below the target width.
- R8: A non-hard host stop with ramp-down enabled keeps stepping, growing the width by rate+1 per step up to RAMP_MAX. The run ends at the first step time found at RAMP_MAX. Without ramp-down, a stop ends the run on the next edge.
- R9: Sensor events are latched and act only when no ramp is in progress. A stop event takes priority over a reverse event. A reverse flips direction, reloads that direction's count, sets its width without ramping and restarts the interval.
- R10: With hard stop enabled, a host stop ends the run on the next edge, even when ramp-down is enabled. Sensor stops still ramp down.
- R11: A stop that ends the run on the next edge takes no step, even when it lands on a step edge.
- R12: `busy` is high while running. `done` pulses for one cycle on the edge where the run ends.
- R13: Out of reset, `coil` is 0 and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| start_req | input | 1 | Start pulse, taken while idle |
| stop_req | input | 1 | Host stop pulse |
| sens_stop | input | 1 | Sensor stop event |
| sens_rev | input | 1 | Sensor reverse event |
| coil | output | 4 | Coil phase signals, bit k drives coil k |
| busy | output | 1 | Motor running |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
An immediate host stop can fall on the same cycle as a step event. In that case the stop must win and the index must not advance. The bench takes the edge of an observed step and adds width×TICK_DIV cycles to find the next step edge, then places a stop so that it is sampled on exactly that edge, with hold set so any step would remain visible. It then requires `busy` to drop, `done` to pulse and the coil pattern to stay at the position shown before that edge.

// File: rtl/step_phase_seq.sv
module step_phase_seq #(
  parameter int TICK_DIV = 4,
  parameter int PW_W     = 16,
  parameter int CNT_W    = 16,
  parameter int RAMP_MAX = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        start_req,
  input  logic        stop_req,
  input  logic        sens_stop,
  input  logic        sens_rev,
  output logic [3:0]  coil,
  output logic        busy,
  output logic        done
);
  localparam int PDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW_W-1:0] WMAX = PW_W'(RAMP_MAX);
  localparam logic [PW_W-1:0] W1   = PW_W'(1);

  logic [1:0]       fmt;
  logic             hold, ru_en, rd_en, hard_en, dir_cfg;
  logic [3:0]       rate;
  logic [PW_W-1:0]  cw_w, ccw_w, cur_w, wcnt;
  logic [CNT_W-1:0] cw_n, ccw_n, rem;
  logic [PDW-1:0]   pre;
  logic [2:0]       idx;
  logic             run, decel, dir, ref_pend, cont, p_stop, p_rev;
  logic [3:0]       one, pat;

  function automatic logic [PW_W-1:0] atleast1(input logic [PW_W-1:0] w);
    return (w == '0) ? W1 : w;
  endfunction

  wire half = (fmt == 2'd2);
  wire tick = (pre == PDW'(TICK_DIV - 1));
  wire [PW_W-1:0]  tgt     = atleast1(dir ? ccw_w : cw_w);
  wire [PW_W-1:0]  tgt_rev = atleast1(dir ? cw_w : ccw_w);
  wire [PW_W-1:0]  tgt_go  = atleast1(dir_cfg ? ccw_w : cw_w);
  wire [CNT_W-1:0] n_go    = dir_cfg ? ccw_n : cw_n;
  wire [CNT_W-1:0] n_rev   = dir ? cw_n : ccw_n;
  wire [PW_W-1:0]  delta   = PW_W'(rate) + W1;

  wire accel     = run && !decel && (cur_w > tgt);
  wire ramping   = accel || decel;
  wire step_ev   = run && tick && (wcnt == cur_w - W1);
  wire host_cut  = run && stop_req && (hard_en || !rd_en);
  wire host_slow = run && stop_req && !hard_en && rd_en;
  wire sens_act  = run && !ramping && p_stop;
  wire cut_now   = host_cut || (sens_act && !rd_en);
  wire rev_now   = run && !ramping && !p_stop && p_rev;

  wire [2:0] idx_adv = dir ? idx - 3'd1 : idx + 3'd1;
  wire [2:0] idx_nxt = half ? idx_adv : {1'b0, idx_adv[1:0]};
  wire [2:0] idx_ref = dir_cfg ? (half ? 3'd7 : 3'd3) : 3'd0;

  always_comb begin
    one = 4'b0001 << (half ? idx[2:1] : idx[1:0]);
    case (fmt)
      2'd1:    pat = one | {one[2:0], one[3]};
      2'd2:    pat = idx[0] ? (one | {one[2:0], one[3]}) : one;
      default: pat = one;
    endcase
  end

  assign coil = (run || (hold && !ref_pend)) ? pat : 4'b0000;
  assign busy = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dir_cfg, hard_en, rate, rd_en, ru_en, hold, fmt} <= '0;
      cw_w <= '0; ccw_w <= '0; cw_n <= '0; ccw_n <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: {dir_cfg, hard_en, rate, rd_en, ru_en, hold, fmt} <= cfg_wdata[10:0];
        3'd1: cw_w  <= PW_W'(cfg_wdata);
        3'd2: ccw_w <= PW_W'(cfg_wdata);
        3'd3: cw_n  <= CNT_W'(cfg_wdata);
        3'd4: ccw_n <= CNT_W'(cfg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + PDW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; decel <= 1'b0; dir <= 1'b0; ref_pend <= 1'b1; cont <= 1'b0;
      p_stop <= 1'b0; p_rev <= 1'b0; done <= 1'b0;
      idx <= '0; cur_w <= '0; wcnt <= '0; rem <= '0;
    end else begin
      done   <= 1'b0;
      p_stop <= run && ((p_stop && ramping) || sens_stop);
      p_rev  <= run && ((p_rev && ramping) || sens_rev);
      if (!run) begin
        if (start_req && !stop_req) begin
          run   <= 1'b1;
          dir   <= dir_cfg;
          decel <= 1'b0;
          wcnt  <= '0;
          cur_w <= (ru_en && WMAX > tgt_go) ? WMAX : tgt_go;
          rem   <= n_go;
          cont  <= (n_go == '0);
          if (ref_pend) begin
            idx      <= idx_ref;
            ref_pend <= 1'b0;
          end
        end
      end else if (cut_now) begin
        run <= 1'b0; done <= 1'b1; decel <= 1'b0;
      end else begin
        if (step_ev) begin
          wcnt <= '0;
          if (decel ? (cur_w >= WMAX) : (!cont && rem == '0)) begin
            run <= 1'b0; done <= 1'b1; decel <= 1'b0;
          end else begin
            idx <= idx_nxt;
            if (decel) cur_w <= (WMAX - cur_w > delta) ? cur_w + delta : WMAX;
            else begin
              if (cur_w > tgt) cur_w <= (cur_w - tgt > delta) ? cur_w - delta : tgt;
              if (!cont) rem <= rem - CNT_W'(1);
            end
          end
        end else if (tick) begin
          wcnt <= wcnt + W1;
        end
        if (host_slow || sens_act) decel <= 1'b1;
        if (rev_now) begin
          dir   <= ~dir;
          rem   <= n_rev;
          cont  <= (n_rev == '0);
          cur_w <= tgt_rev;
          wcnt  <= '0;
        end
      end
    end
  end

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R12
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(busy)) |-> done);
  // R10
  hard_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_req && hard_en) |=> !busy);
  // R2
  wave_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fmt == 2'd0) |-> $countones(coil) == 1);
  // R2
  two_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fmt == 2'd1) |-> $countones(coil) == 2);
  // R4
  step_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && idx != $past(idx)) |-> $past(tick));
  // R7
  accel_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !decel && !$past(decel) && dir == $past(dir) && cur_w != $past(cur_w))
    |-> cur_w < $past(cur_w));
  // R8
  decel_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && decel && $past(busy) && $past(decel)) |-> cur_w >= $past(cur_w));
  // R9
  rev_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dir != $past(dir)) |-> !$past(ramping));
endmodule

// File: tb/step_phase_seq_tb_top.sv
module step_phase_seq_tb_top;
  localparam int D = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, start_req = 0, stop_req = 0, sens_stop = 0, sens_rev = 0;
  logic [2:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [3:0]  coil;
  logic        busy, done;

  step_phase_seq #(.TICK_DIV(D), .RAMP_MAX(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start_req(start_req), .stop_req(stop_req), .sens_stop(sens_stop), .sens_rev(sens_rev),
    .coil(coil), .busy(busy), .done(done));

  always #5 clk = ~clk;

  typedef struct { logic [3:0] p; int gap; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int nchk = 0, nerr = 0, cyc = 0, t_last = 0, done_cnt = 0;
  bit mon_on = 0;
  logic [3:0] last_coil;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pt(input int f, input int i);
    logic [3:0] w[4] = '{4'h1, 4'h2, 4'h4, 4'h8};
    logic [3:0] t[4] = '{4'h3, 4'h6, 4'hC, 4'h9};
    logic [3:0] h[8] = '{4'h1, 4'h3, 4'h2, 4'h6, 4'h4, 4'hC, 4'h8, 4'h9};
    if (f == 1) return t[i % 4];
    if (f == 2) return h[i % 8];
    return w[i % 4];
  endfunction

  function automatic logic [15:0] ctl(int f, int hd, int ru, int rd, int rt, int hs, int ccw);
    return 16'((ccw << 10) | (hs << 9) | (rt << 5) | (rd << 4) | (ru << 3) | (hd << 2) | f);
  endfunction

  task automatic push(input logic [3:0] p, input int gap, input string tag);
    exp_t x;
    x.p = p; x.gap = gap; x.tag = tag;
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (done) done_cnt++;
    if (mon_on && coil !== last_coil) begin
      if (q.size() == 0) chk(0, "R2", "unexpected coil change", int'(coil), int'(last_coil));
      else begin
        e = q.pop_front();
        chk(coil == e.p, e.tag, "coil pattern", int'(coil), int'(e.p));
        if (e.gap > 0) chk(cyc - t_last == e.gap, e.tag, "step interval", cyc - t_last, e.gap);
      end
      t_last = cyc;
      last_coil = coil;
    end
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic mon_start();
    @(negedge clk); last_coil = coil; t_last = cyc; mon_on = 1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    chk(busy == 1, "R12", "busy after start", busy, 1);
  endtask

  task automatic wait_coil(input logic [3:0] p, input string tag);
    for (int n = 0; n < 3000 && coil != p; n++) @(negedge clk);
    chk(coil == p, tag, "reached pattern", int'(coil), int'(p));
  endtask

  task automatic wait_drain(input string tag);
    for (int n = 0; n < 5000 && (q.size() != 0 || busy); n++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !busy, tag, "run completed, items left", q.size(), 0);
    mon_on = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13
    chk(coil == 0 && !busy && !done, "R13", "reset outputs", {coil, busy, done}, 0);

    // R1 R3 R4 R5 R6: first start clockwise, wave, 3 steps, hold off
    cfg_wr(0, ctl(0, 0, 0, 0, 0, 0, 0));
    cfg_wr(1, 16'd3);
    cfg_wr(3, 16'd3);
    mon_start();
    push(pt(0, 0), 0, "R3");
    push(pt(0, 1), 0, "R4");
    push(pt(0, 2), 3 * D, "R4");
    push(pt(0, 3), 3 * D, "R1");
    push(4'h0, 3 * D, "R5");
    d0 = done_cnt;
    pulse_start();
    wait_drain("R5");
    chk(done_cnt - d0 == 1, "R12", "done pulses", done_cnt - d0, 1);

    // R2 R6: half-step counter-clockwise from index 3, hold on
    cfg_wr(0, ctl(2, 1, 0, 0, 0, 0, 1));
    cfg_wr(2, 16'd2);
    cfg_wr(4, 16'd4);
    @(negedge clk);
    chk(coil == pt(2, 3), "R6", "held pattern in idle", coil, pt(2, 3));
    mon_start();
    push(pt(2, 2), 0, "R2");
    push(pt(2, 1), 2 * D, "R4");
    push(pt(2, 0), 2 * D, "R2");
    push(pt(2, 7), 2 * D, "R2");
    pulse_start();
    wait_drain("R5");
    chk(coil == pt(2, 7), "R6", "hold after run", coil, pt(2, 7));

    // R3 R4: reset, counter-clockwise reference, width 0 acts as 1
    do_reset();
    cfg_wr(0, ctl(0, 0, 0, 0, 0, 0, 1));
    cfg_wr(2, 16'd0);
    cfg_wr(4, 16'd1);
    mon_start();
    push(pt(0, 3), 0, "R3");
    push(pt(0, 2), 0, "R4");
    push(4'h0, 1 * D, "R4");
    pulse_start();
    wait_drain("R3");

    // R7 R9 R10: two-phase ramp-up, reverse deferred, hard stop
    cfg_wr(0, ctl(1, 0, 1, 1, 3, 1, 0));
    cfg_wr(1, 16'd4);
    cfg_wr(3, 16'd0);
    cfg_wr(2, 16'd5);
    cfg_wr(4, 16'd0);
    mon_start();
    push(pt(1, 2), 0, "R3");
    push(pt(1, 3), 0, "R7");
    push(pt(1, 0), 16 * D, "R7");
    push(pt(1, 1), 12 * D, "R7");
    push(pt(1, 2), 8 * D, "R9");
    push(pt(1, 1), 0, "R9");
    push(pt(1, 0), 5 * D, "R9");
    push(pt(1, 3), 5 * D, "R9");
    pulse_start();
    wait_coil(pt(1, 3), "R7");
    @(negedge clk); sens_rev = 1;
    @(negedge clk); sens_rev = 0;
    for (int n = 0; n < 3000 && q.size() != 0; n++) @(negedge clk);
    push(4'h0, 0, "R10");
    d0 = done_cnt;
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk(!busy && coil == 0, "R10", "hard stop", {busy, coil}, 0);
    wait_drain("R10");
    chk(done_cnt - d0 == 1, "R12", "done on hard stop", done_cnt - d0, 1);

    // R8 R9 R10: sensor stop decelerates even with hard stop set
    cfg_wr(0, ctl(0, 0, 0, 1, 7, 1, 0));
    cfg_wr(1, 16'd6);
    mon_start();
    push(pt(0, 3), 0, "R3");
    push(pt(0, 0), 0, "R4");
    push(pt(0, 1), 6 * D, "R4");
    push(pt(0, 2), 6 * D, "R8");
    push(pt(0, 3), 14 * D, "R8");
    push(4'h0, 20 * D, "R8");
    pulse_start();
    wait_coil(pt(0, 1), "R9");
    repeat (2) @(negedge clk);
    sens_stop = 1;
    @(negedge clk); sens_stop = 0;
    wait_drain("R8");

    // R11: immediate host stop sampled on a step edge takes no step
    cfg_wr(0, ctl(0, 1, 0, 0, 0, 0, 0));
    cfg_wr(1, 16'd3);
    @(negedge clk);
    chk(coil == pt(0, 3), "R6", "held pattern before start", coil, pt(0, 3));
    mon_start();
    push(pt(0, 0), 0, "R4");
    push(pt(0, 1), 3 * D, "R4");
    d0 = done_cnt;
    pulse_start();
    wait_coil(pt(0, 1), "R11");
    repeat (3 * D - 1) @(negedge clk);
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk(!busy, "R8", "stop without ramp-down halts next edge", busy, 0);
    chk(coil == pt(0, 1), "R11", "no step on stop edge", coil, pt(0, 1));
    repeat (20) @(negedge clk);
    chk(coil == pt(0, 1) && q.size() == 0, "R11", "position kept", coil, pt(0, 1));
    chk(done_cnt - d0 == 1, "R12", "done on stop", done_cnt - d0, 1);
    mon_on = 0;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule